// File: doc/BRIEF.md
# Oversampling UART Receiver with Two-Entry Receive Queue

This block recovers asynchronous NRZ words from a serial line. It runs from a system clock and counts sample ticks. The ticks come from outside the block at sixteen times the bit rate. A falling edge on the idle line starts a frame. The start bit must be confirmed low at mid-bit, or the receiver drops it as a glitch. Each bit is then decided by a majority vote over three samples taken near the centre of the bit. Data arrives LSB first, with 8 or 9 data bits followed by one stop bit.

A finished word goes into a two-entry queue, and the word carries its own ninth bit and framing-error status. The host reads the head of the queue through a one-cycle read strobe. An overrun flag records a word lost to a full queue. The flag is sticky and blocks every later write into the queue. Dropping the receive enable clears it and resets the frame recovery logic. Dropping the enable does not discard words already queued.

Top module: `uart_os_rx`

## Requirements
- R1: After reset, avail_o, ovr_o, frm_err_o and ninth_o are 0 and data_o is 0.
- R2: Tick 1 of a bit is the first tick at which the start bit is seen low. Bit periods follow on from there, 16 ticks each. Every bit takes the majority of the samples at ticks 7, 8 and 9 of its period. A disagreement at one of these ticks does not change the bit, disagreements at two of them do, and ticks outside 7 to 9 have no effect.
- R3: A start bit whose majority vote is high is dropped. No word is stored, and the receiver goes back to waiting for a falling edge.
- R4: Data bits are received LSB first. When nine_bit_i is 1 at the start of the frame, 9 data bits are received and the ninth appears on ninth_o. When nine_bit_i is 0, 8 data bits are received and ninth_o reads 0. data_o carries data bits 0 to 7.
- R5: When the stop bit is decided, the word is written into the queue if the queue has room and ovr_o is 0. avail_o is then 1.
- R6: The queue holds two words. The first word written is the first word presented. Each rd_i pulse while avail_o is 1 removes the head entry.
- R7: A stop bit decided low sets the framing-error status of that word only. frm_err_o shows the status of the head entry and changes with it on each read.
- R8: When a stop bit is decided while the queue already holds two words, ovr_o goes to 1, the word is discarded and the queued words are unchanged. ovr_o stays at 1 while rx_en_i stays at 1.
- R9: While ovr_o is 1, no word is written into the queue, even when the queue has room.
- R10: While rx_en_i is 0, ovr_o is 0 and frames on rx_i are ignored. Words already in the queue are kept and can still be read.
- R11: When the queue is empty, avail_o, data_o, ninth_o and frm_err_o read 0. A rd_i pulse on an empty queue has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sample tick, one clock wide, at 16 times the bit rate |
| rx_i | input | 1 | Serial input, idle high |
| rx_en_i | input | 1 | Continuous receive enable. Low clears the overrun flag and resets frame recovery |
| nine_bit_i | input | 1 | Selects 9 data bits per frame; sampled at the start of each frame |
| rd_i | input | 1 | Read strobe; removes the head entry of the queue |
| data_o | output | 8 | Data bits 0 to 7 of the head entry |
| ninth_o | output | 1 | Ninth data bit of the head entry |
| frm_err_o | output | 1 | Framing-error status of the head entry |
| avail_o | output | 1 | Queue holds at least one word |
| ovr_o | output | 1 | Sticky overrun flag |

## Verification
The bench builds the block with its default parameters:
- 8 data bits;
- 16 ticks per bit;
- a queue of two entries;
- two synchroniser stages.

It generates a tick every four clocks, so the bench knows which tick sees each value it drives on the line. With that alignment it can invert single ticks and pairs of ticks inside and outside the 7-to-9 window. With a queue only two deep, the third word reaches overrun quickly. That makes it practical to run the whole sequence: overrun, the blocked write after the queue has been drained, and recovery through the enable.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/uart_os_rx_sync.sv
module uart_os_rx_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= RESET_VAL;
        else         sync_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= {STAGES{RESET_VAL}};
        else         sync_q <= {sync_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sync_q[STAGES-1];

endmodule

// File: rtl/uart_os_rx_deframer.sv
module uart_os_rx_deframer
  import uart_os_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic              nine_i,
  output logic              word_vld_o,
  output logic [DATA_W-1:0] word_o,
  output logic              ninth_o,
  output logic              ferr_o
);

  localparam int CNT_W = $clog2(OSR);
  localparam int SH_W  = DATA_W + 1;
  localparam int IDX_W = $clog2(SH_W);
  localparam logic [CNT_W-1:0] SMP_A = CNT_W'(OSR / 2 - 2);
  localparam logic [CNT_W-1:0] SMP_B = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] SMP_C = CNT_W'(OSR / 2);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);

  rx_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       smp_q;
  logic [IDX_W-1:0] idx_q;
  logic [SH_W-1:0]  sh_q;
  logic             nine_q;
  logic             vld_q;
  logic             ferr_q;

  logic vote;
  logic last_bit;

  assign vote     = maj3(smp_q[0], smp_q[1], rx_i);
  assign last_bit = nine_q ? (idx_q == IDX_W'(DATA_W)) : (idx_q == IDX_W'(DATA_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      smp_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      nine_q  <= 1'b0;
      vld_q   <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (!en_i) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
      end else if (tick_i) begin
        if (state_q == ST_IDLE) begin
          // first low tick counts as tick 1 of the start bit
          if (!rx_i) begin
            state_q <= ST_START;
            cnt_q   <= CNT_W'(1);
            nine_q  <= nine_i;
            idx_q   <= '0;
          end
        end else begin
          cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
          if (cnt_q == SMP_A) smp_q[0] <= rx_i;
          if (cnt_q == SMP_B) smp_q[1] <= rx_i;
          if (cnt_q == SMP_C) begin
            case (state_q)
              ST_START: state_q <= vote ? ST_IDLE : ST_DATA;
              ST_DATA: begin
                sh_q <= {vote, sh_q[SH_W-1:1]};
                if (last_bit) state_q <= ST_STOP;
                else          idx_q   <= idx_q + 1'b1;
              end
              ST_STOP: begin
                vld_q   <= 1'b1;
                ferr_q  <= ~vote;
                state_q <= ST_IDLE;
              end
              default: state_q <= ST_IDLE;
            endcase
          end
        end
      end
    end
  end

  // 8-bit frames leave the word one place higher in the shifter
  assign word_o     = nine_q ? sh_q[DATA_W-1:0] : sh_q[SH_W-1:1];
  assign ninth_o    = nine_q & sh_q[SH_W-1];
  assign ferr_o     = ferr_q;
  assign word_vld_o = vld_q;

endmodule

// File: rtl/uart_os_rx_fifo.sv
module uart_os_rx_fifo #(
  parameter int ENT_W = 10,
  parameter int DEPTH = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [ENT_W-1:0] entry_i,
  input  logic             pop_i,
  input  logic             clr_ovr_i,
  output logic [ENT_W-1:0] head_o,
  output logic             avail_o,
  output logic             ovr_o,
  output logic [CNT_W-1:0] cnt_o
);

  logic [ENT_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovr_q;

  logic full, empty, push_ok, pop_ok, set_ovr;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push_i && !ovr_q && !full;
  assign set_ovr = push_i && !ovr_q && full;
  assign pop_ok  = pop_i && !empty;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovr_q    <= 1'b0;
    end else begin
      if (push_ok) begin
        for (int i = 0; i < DEPTH; i++)
          if (wr_ptr_q == PTR_W'(i)) mem_q[i] <= entry_i;
        wr_ptr_q <= ptr_next(wr_ptr_q);
      end
      if (pop_ok) rd_ptr_q <= ptr_next(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      if (clr_ovr_i)    ovr_q <= 1'b0;
      else if (set_ovr) ovr_q <= 1'b1;
    end
  end

  assign head_o  = empty ? '0 : mem_q[rd_ptr_q];
  assign avail_o = !empty;
  assign ovr_o   = ovr_q;
  assign cnt_o   = cnt_q;

endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx #(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int FIFO_DEPTH  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic              rx_en_i,
  input  logic              nine_bit_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ninth_o,
  output logic              frm_err_o,
  output logic              avail_o,
  output logic              ovr_o
);

  localparam int ENT_W = DATA_W + 2;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic              rx_s;
  logic              word_vld;
  logic [DATA_W-1:0] word;
  logic              word_ninth;
  logic              word_ferr;
  logic [ENT_W-1:0]  head;
  logic [CNT_W-1:0]  fifo_cnt;

  uart_os_rx_sync #(
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(1'b1)
  ) sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (rx_s)
  );

  uart_os_rx_deframer #(
    .DATA_W(DATA_W),
    .OSR   (OSR)
  ) deframer_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (rx_en_i),
    .tick_i    (tick_i),
    .rx_i      (rx_s),
    .nine_i    (nine_bit_i),
    .word_vld_o(word_vld),
    .word_o    (word),
    .ninth_o   (word_ninth),
    .ferr_o    (word_ferr)
  );

  uart_os_rx_fifo #(
    .ENT_W(ENT_W),
    .DEPTH(FIFO_DEPTH)
  ) fifo_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (word_vld),
    .entry_i  ({word_ferr, word_ninth, word}),
    .pop_i    (rd_i),
    .clr_ovr_i(!rx_en_i),
    .head_o   (head),
    .avail_o  (avail_o),
    .ovr_o    (ovr_o),
    .cnt_o    (fifo_cnt)
  );

  assign data_o    = head[DATA_W-1:0];
  assign ninth_o   = head[DATA_W];
  assign frm_err_o = head[DATA_W+1];

endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_en_i,
  input logic              rd_i,
  input logic [DATA_W-1:0] data_o,
  input logic              ninth_o,
  input logic              frm_err_o,
  input logic              avail_o,
  input logic              ovr_o,
  input logic              word_vld,
  input logic [CNT_W-1:0]  fifo_cnt
);

  assert_empty_head_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !avail_o |-> (data_o == '0 && !ninth_o && !frm_err_o));

  assert_word_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld |=> !word_vld);

  assert_word_lands_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_vld && !ovr_o && fifo_cnt < CNT_W'(DEPTH)) |=> avail_o);

  assert_depth_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt <= CNT_W'(DEPTH));

  assert_pop_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && avail_o && !word_vld) |=> (fifo_cnt == $past(fifo_cnt) - 1'b1));

  assert_ovr_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && rx_en_i) |=> ovr_o);

  assert_no_fill_in_ovr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |=> (fifo_cnt <= $past(fifo_cnt)));

  assert_ovr_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> !ovr_o);

endmodule

bind uart_os_rx uart_os_rx_chk #(
  .DATA_W(DATA_W),
  .DEPTH (FIFO_DEPTH)
) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rx_en_i  (rx_en_i),
  .rd_i     (rd_i),
  .data_o   (data_o),
  .ninth_o  (ninth_o),
  .frm_err_o(frm_err_o),
  .avail_o  (avail_o),
  .ovr_o    (ovr_o),
  .word_vld (word_vld),
  .fifo_cnt (fifo_cnt)
);

// File: tb/uart_os_rx_tb_top.sv
module uart_os_rx_tb_top;

  localparam int OSR      = 16;
  localparam int TICK_DIV = 4;
  localparam int N_VEC    = 7;
  // {nine, word[8:0], stop}
  localparam logic [10:0] VECS [N_VEC] = '{
    {1'b0, 9'h0A5, 1'b1},
    {1'b1, 9'h15A, 1'b1},
    {1'b0, 9'h0FF, 1'b0},
    {1'b1, 9'h100, 1'b0},
    {1'b0, 9'h001, 1'b1},
    {1'b1, 9'h0C3, 1'b1},
    {1'b0, 9'h180, 1'b1}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       tick_i;
  logic       rx_i;
  logic       rx_en_i;
  logic       nine_bit_i;
  logic       rd_i;
  logic [7:0] data_o;
  logic       ninth_o, frm_err_o, avail_o, ovr_o;

  int n_chk = 0;
  int n_err = 0;
  int tdiv  = 0;

  uart_os_rx #(
    .DATA_W(8), .OSR(OSR), .FIFO_DEPTH(2), .SYNC_STAGES(2)
  ) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .rx_i(rx_i),
    .rx_en_i(rx_en_i), .nine_bit_i(nine_bit_i), .rd_i(rd_i),
    .data_o(data_o), .ninth_o(ninth_o), .frm_err_o(frm_err_o),
    .avail_o(avail_o), .ovr_o(ovr_o)
  );

  always #2.5 clk_i = ~clk_i;

  initial begin
    tick_i = 1'b0;
    forever begin
      @(negedge clk_i);
      tdiv   = (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
      tick_i = (tdiv == 0);
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_err++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // value set here is seen by the next tick
  task automatic drive_slot(input logic v);
    do @(posedge clk_i); while (!tick_i);
    @(negedge clk_i);
    rx_i = v;
  endtask

  task automatic send_bit(input logic v, input logic [15:0] inv);
    for (int j = 0; j < OSR; j++) drive_slot(v ^ inv[j]);
  endtask

  task automatic send_frame(input logic [8:0] w, input logic nine, input logic stop,
                            input logic [15:0] start_inv, input logic [15:0] b0_inv);
    nine_bit_i = nine;
    send_bit(1'b0, start_inv);
    for (int j = 0; j < (nine ? 9 : 8); j++) send_bit(w[j], (j == 0) ? b0_inv : 16'h0);
    send_bit(stop, 16'h0);
    send_bit(1'b1, 16'h0);
    send_bit(1'b1, 16'h0);
  endtask

  task automatic pop();
    @(negedge clk_i) rd_i = 1'b1;
    @(negedge clk_i) rd_i = 1'b0;
    @(negedge clk_i);
  endtask

  initial begin
    rst_ni = 1'b0; rx_i = 1'b1; rx_en_i = 1'b1; nine_bit_i = 1'b0; rd_i = 1'b0;
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    check("R1", "avail", 32'(avail_o), 0);
    check("R1", "ovr", 32'(ovr_o), 0);
    check("R1", "data", 32'(data_o), 0);
    check("R1", "ferr", 32'(frm_err_o), 0);
    check("R1", "ninth", 32'(ninth_o), 0);
    send_bit(1'b1, 16'h0);

    // vector table: R4 R5 R7 R11
    for (int v = 0; v < N_VEC; v++) begin
      send_frame(VECS[v][9:1], VECS[v][10], VECS[v][0], 16'h0, 16'h0);
      check("R5", "avail after frame", 32'(avail_o), 1);
      check("R4", "data", 32'(data_o), 32'(VECS[v][8:1]));
      check("R4", "ninth", 32'(ninth_o), 32'(VECS[v][10] & VECS[v][9]));
      check("R7", "ferr", 32'(frm_err_o), 32'(!VECS[v][0]));
      pop();
      check("R11", "avail after last read", 32'(avail_o), 0);
      check("R11", "data when empty", 32'(data_o), 0);
    end

    // R6 R7 R8 ordering, per-entry status, overrun
    send_frame(9'h031, 1'b0, 1'b0, 16'h0, 16'h0);
    send_frame(9'h042, 1'b0, 1'b1, 16'h0, 16'h0);
    check("R8", "no ovr at two", 32'(ovr_o), 0);
    send_frame(9'h053, 1'b0, 1'b1, 16'h0, 16'h0);
    check("R8", "ovr set on third", 32'(ovr_o), 1);
    check("R6", "head first", 32'(data_o), 32'h31);
    check("R7", "head ferr", 32'(frm_err_o), 1);
    pop();
    check("R6", "head second", 32'(data_o), 32'h42);
    check("R7", "ferr advances", 32'(frm_err_o), 0);
    pop();
    check("R8", "third word lost", 32'(avail_o), 0);
    check("R8", "ovr sticky", 32'(ovr_o), 1);

    // R9 blocked while overrun
    send_frame(9'h064, 1'b0, 1'b1, 16'h0, 16'h0);
    check("R9", "no write in ovr", 32'(avail_o), 0);

    // R10 enable low clears overrun and ignores frames
    @(negedge clk_i) rx_en_i = 1'b0;
    @(negedge clk_i);
    check("R10", "ovr cleared", 32'(ovr_o), 0);
    send_frame(9'h075, 1'b0, 1'b1, 16'h0, 16'h0);
    check("R10", "frame ignored", 32'(avail_o), 0);
    rx_en_i = 1'b1;
    send_frame(9'h086, 1'b0, 1'b1, 16'h0, 16'h0);
    check("R10", "resumes", 32'(data_o), 32'h86);
    @(negedge clk_i) rx_en_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R10", "queue kept", 32'(avail_o), 1);
    check("R10", "queue kept data", 32'(data_o), 32'h86);
    rx_en_i = 1'b1;
    pop();

    // R11 read on empty
    pop();
    check("R11", "empty read", 32'(avail_o), 0);
    send_frame(9'h0A8, 1'b0, 1'b1, 16'h0, 16'h0);
    check("R11", "after empty read", 32'(data_o), 32'hA8);
    pop();

    // R3 short start glitch
    for (int j = 0; j < 4; j++) drive_slot(1'b0);
    for (int j = 0; j < 48; j++) drive_slot(1'b1);
    check("R3", "glitch dropped", 32'(avail_o), 0);
    send_frame(9'h05C, 1'b0, 1'b1, 16'h0, 16'h0);
    check("R3", "next frame ok", 32'(data_o), 32'h5C);
    pop();
    send_frame(9'h03C, 1'b0, 1'b1, 16'h0080, 16'h0);
    check("R2", "start one bad sample", 32'(data_o), 32'h3C);
    pop();

    // R2 sample window
    send_frame(9'h001, 1'b0, 1'b1, 16'h0, 16'h0080);
    check("R2", "one of three flipped", 32'(data_o), 32'h01);
    pop();
    send_frame(9'h001, 1'b0, 1'b1, 16'h0, 16'h0140);
    check("R2", "two of three flipped", 32'(data_o), 32'h00);
    pop();
    send_frame(9'h001, 1'b0, 1'b1, 16'h0, 16'h0220);
    check("R2", "outside window", 32'(data_o), 32'h01);
    pop();

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule